// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Interlock Controller

This block is the digital gate-enable logic for one inverter leg. It receives three asynchronous control lines: a request for the upper switch (active high), a request for the lower switch (active low), and an arm line that must be high for either gate to conduct. It produces one registered enable for each gate. Both enables are never high together. Whenever conduction passes from one switch to the other, a programmable dead time separates the two.

The inputs first pass through a two-stage synchronizer. A decoder then reduces them to one of four requests: idle, upper, lower, or blocked. A request is blocked when the leg is disarmed or when both switches are requested at once. A single dead-time counter gates every turn-on that follows a turn-off, a blocked period or another request change. A turn-on that comes long after the last turn-off goes through without delay. Because the two request inputs have opposite polarities, one PWM signal wired to both of them gives complementary switching with dead time inserted automatically. Three instances form a three-phase bridge.

Top module: `leg_deadband_ctrl`

## Requirements
- R1: During reset both gate enables are low. A single request held through reset asserts its gate exactly 3 + DEAD_CYCLES cycles after the first clock edge at which reset is sampled low.
- R2: `hi_cmd` = 1 requests the upper switch and `lo_cmd_n` = 0 requests the lower switch. When one switch alone is requested after the dead-time counter has expired, its gate rises 3 cycles after the input change (two synchronizer stages plus the output register). A gate is only ever high when its own request was present 3 cycles earlier.
- R3: With no switch requested (`hi_cmd` = 0, `lo_cmd_n` = 1), both enables go low 3 cycles after the inputs reach that state.
- R4: With both switches requested (`hi_cmd` = 1, `lo_cmd_n` = 0), both enables go low within 3 cycles and stay low for as long as the overlap lasts.
- R5: With `arm` low, both enables go low 3 cycles later and stay low whatever the request inputs do.
- R6: Every rising edge of either enable follows at least DEAD_CYCLES consecutive cycles in which both enables were low. On a direct hand-over, the incoming gate rises exactly DEAD_CYCLES cycles after the outgoing gate falls.
- R7: When the blocked state ends (overlap removed or `arm` raised) and a single request remains, that gate rises 3 + DEAD_CYCLES cycles after the input change, however long the blocked period was.
- R8: If the request changes while the dead-time counter is still running, the counter restarts. The new gate rises 3 + DEAD_CYCLES cycles after that later change.
- R9: `hi_gate` and `lo_gate` are never high in the same cycle.
- R10: With `hi_cmd` and `lo_cmd_n` driven by one signal, a 1 selects the upper gate and a 0 selects the lower gate, with a DEAD_CYCLES gap at each transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd | input | 1 | Upper-switch request, active high, asynchronous |
| lo_cmd_n | input | 1 | Lower-switch request, active low, asynchronous |
| arm | input | 1 | Leg enable; low forces both gates off |
| hi_gate | output | 1 | Upper gate enable |
| lo_gate | output | 1 | Lower gate enable |

## Verification
The hardest case to reach is a request change that lands while the dead-time counter is still counting, because the counter cannot be seen at the ports. The stimulus reaches it by reversing a hand-over only a few cycles after the outgoing gate has fallen. It then checks that the gate that would have been granted under the old timing stays low at that exact cycle, and that the new gate rises one full dead time after the second change. The same idea covers two other cases: an overlap that is shorter than the dead time, and an idle gap that is shorter than the dead time.

// File: rtl/leg_pkg.sv
package leg_pkg;

    // synchronizer depth; the checker and the latency figures assume 2
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_HIGH  = 2'd1,
        REQ_LOW   = 2'd2,
        REQ_BLOCK = 2'd3
    } leg_req_e;

    typedef struct packed {
        logic hi;    // upper request, active high
        logic lo_n;  // lower request, active low
        logic arm;   // leg enable
    } leg_cmd_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_t;

    // safe value for the synchronizer at reset: disarmed, nothing requested
    localparam leg_cmd_t CMD_SAFE = '{hi: 1'b0, lo_n: 1'b1, arm: 1'b0};

    function automatic leg_req_e decode_cmd(input leg_cmd_t c);
        if (!c.arm || (c.hi && !c.lo_n))
            return REQ_BLOCK;
        else if (c.hi)
            return REQ_HIGH;
        else if (!c.lo_n)
            return REQ_LOW;
        else
            return REQ_IDLE;
    endfunction

    function automatic gate_t gates_for(input leg_req_e r);
        gate_t g;
        g.hi = (r == REQ_HIGH);
        g.lo = (r == REQ_LOW);
        return g;
    endfunction

endpackage

// File: rtl/leg_sync.sv
module leg_sync #(
    parameter int           W       = 3,
    parameter int           DEPTH   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= RST_VAL;
                else     stage[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= RST_VAL;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/leg_dead_timer.sv
module leg_dead_timer #(
    parameter int DEAD_CYCLES = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(DEAD_CYCLES) + 1;
    localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= RELOAD;
        else if (load)
            cnt <= RELOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/leg_handover.sv
module leg_handover
    import leg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  leg_req_e req,
    input  logic     expired,
    output logic     load,
    output gate_t    gate
);
    leg_req_e req_prev;
    gate_t    gate_d;
    logic     off_evt, exit_blk, retrig;

    always_comb begin
        off_evt  = (gate.hi && req != REQ_HIGH) || (gate.lo && req != REQ_LOW);
        exit_blk = (req_prev == REQ_BLOCK) && (req != REQ_BLOCK);
        retrig   = !expired && (req != req_prev);
        load     = off_evt || exit_blk || retrig;
        if (expired && !load)
            gate_d = gates_for(req);
        else
            gate_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate     <= '0;
            req_prev <= REQ_BLOCK;
        end else begin
            gate     <= gate_d;
            req_prev <= req;
        end
    end
endmodule

// File: rtl/leg_deadband_ctrl.sv
module leg_deadband_ctrl
    import leg_pkg::*;
#(
    parameter int DEAD_CYCLES = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_cmd,
    input  logic lo_cmd_n,
    input  logic arm,
    output logic hi_gate,
    output logic lo_gate
);
    localparam int CMD_W = $bits(leg_cmd_t);

    leg_cmd_t       raw_cmd, sync_cmd;
    logic [CMD_W-1:0] sync_bits;
    leg_req_e       req;
    logic           load, expired;
    gate_t          gate;

    assign raw_cmd = '{hi: hi_cmd, lo_n: lo_cmd_n, arm: arm};

    leg_sync #(
        .W      (CMD_W),
        .DEPTH  (SYNC_DEPTH),
        .RST_VAL(CMD_SAFE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_cmd),
        .q  (sync_bits)
    );

    assign sync_cmd = leg_cmd_t'(sync_bits);
    assign req      = decode_cmd(sync_cmd);

    leg_dead_timer #(
        .DEAD_CYCLES(DEAD_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .expired(expired)
    );

    leg_handover u_hand (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .expired(expired),
        .load   (load),
        .gate   (gate)
    );

    assign hi_gate = gate.hi;
    assign lo_gate = gate.lo;
endmodule

// File: rtl/leg_deadband_ctrl_chk.sv
module leg_deadband_ctrl_chk #(
    parameter int DEAD_CYCLES = 60
) (
    input logic clk,
    input logic rst,
    input logic hi_cmd,
    input logic lo_cmd_n,
    input logic arm,
    input logic hi_gate,
    input logic lo_gate
);
    localparam int RW = $clog2(DEAD_CYCLES + 1) + 1;

    // consecutive cycles with both gates low, saturating
    logic [RW-1:0] quiet_run;

    always_ff @(posedge clk) begin
        if (rst || hi_gate || lo_gate)
            quiet_run <= '0;
        else if (quiet_run < RW'(DEAD_CYCLES))
            quiet_run <= quiet_run + 1'b1;
    end

    // R9: no shoot-through
    p_never_both_r9: assert property (@(posedge clk) disable iff (rst)
        !(hi_gate && lo_gate));

    // R5: three sampled disarmed cycles leave both gates low
    p_disarm_off_r5: assert property (@(posedge clk) disable iff (rst)
        (!arm && !$past(arm) && !$past(arm, 2)) |=> (!hi_gate && !lo_gate));

    // R2: upper gate only with its own request, 3 cycles of latency
    p_hi_needs_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        hi_gate |-> ($past(hi_cmd, 3) && $past(lo_cmd_n, 3) && $past(arm, 3)));

    // R2: lower gate only with its own request
    p_lo_needs_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        lo_gate |-> (!$past(lo_cmd_n, 3) && !$past(hi_cmd, 3) && $past(arm, 3)));

    // R6: each turn-on follows a full dead time of both gates low
    p_dead_gap_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(hi_gate) || $rose(lo_gate)) |-> (quiet_run >= RW'(DEAD_CYCLES)));
endmodule

bind leg_deadband_ctrl leg_deadband_ctrl_chk #(
    .DEAD_CYCLES(DEAD_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .hi_cmd  (hi_cmd),
    .lo_cmd_n(lo_cmd_n),
    .arm     (arm),
    .hi_gate (hi_gate),
    .lo_gate (lo_gate)
);

// File: tb/leg_deadband_ctrl_tb.sv
module leg_deadband_ctrl_tb;
    localparam int DEAD = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, hi_cmd, lo_cmd_n, arm;
    logic hi_gate, lo_gate;

    leg_deadband_ctrl #(.DEAD_CYCLES(DEAD)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .hi_cmd  (hi_cmd),
        .lo_cmd_n(lo_cmd_n),
        .arm     (arm),
        .hi_gate (hi_gate),
        .lo_gate (lo_gate)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        logic  h;
        logic  l;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   t0 = 0;
    int   n_chk = 0;
    int   n_fail = 0;

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check_now(input logic h, input logic l, input string tag);
        n_chk++;
        if (hi_gate !== h || lo_gate !== l) begin
            n_fail++;
            $display("FAIL %s: hi_gate=%b lo_gate=%b expected %b %b at cycle %0d",
                     tag, hi_gate, lo_gate, h, l, cyc);
        end
    endtask

    // monitor: pop expected items as their cycle comes up
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            if (e.at != cyc) begin
                n_chk++;
                n_fail++;
                $display("FAIL %s: item for cycle %0d seen at %0d, expected on time",
                         e.tag, e.at, cyc);
            end else begin
                check_now(e.h, e.l, e.tag);
            end
        end
    end

    task automatic drive(input logic h, input logic l_n, input logic a);
        @(negedge clk);
        hi_cmd   = h;
        lo_cmd_n = l_n;
        arm      = a;
        t0       = cyc;
    endtask

    task automatic expect_at(input int off, input logic h, input logic l, input string tag);
        sbq.push_back('{t0 + off, h, l, tag});
    endtask

    task automatic idle_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1; hi_cmd = 1'b1; lo_cmd_n = 1'b1; arm = 1'b1;
        idle_for(5);
        check_now(1'b0, 1'b0, "R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        t0  = cyc;
        expect_at(3 + DEAD - 1, 1'b0, 1'b0, "R1 held off after reset");
        expect_at(3 + DEAD,     1'b1, 1'b0, "R1 first turn-on");
        drain();

        // R3 idle
        drive(1'b0, 1'b1, 1'b1);
        expect_at(2, 1'b1, 1'b0, "R3 before latency");
        expect_at(3, 1'b0, 1'b0, "R3 idle off");
        drain(); idle_for(DEAD + 4);

        // R2 direct drive of lower switch
        drive(1'b0, 1'b0, 1'b1);
        expect_at(2, 1'b0, 1'b0, "R2 lower latency");
        expect_at(3, 1'b0, 1'b1, "R2 lower direct");
        drain();
        drive(1'b0, 1'b1, 1'b1);
        expect_at(3, 1'b0, 1'b0, "R3 idle after lower");
        drain(); idle_for(DEAD + 4);
        drive(1'b1, 1'b1, 1'b1);
        expect_at(2, 1'b0, 1'b0, "R2 upper latency");
        expect_at(3, 1'b1, 1'b0, "R2 upper direct");
        drain();

        // R10 / R6 tied inputs, signal goes 0
        drive(1'b0, 1'b0, 1'b1);
        expect_at(3,            1'b0, 1'b0, "R10 upper released");
        expect_at(3 + DEAD - 1, 1'b0, 1'b0, "R6 gap end");
        expect_at(3 + DEAD,     1'b0, 1'b1, "R6 lower after gap");
        drain();
        drive(1'b1, 1'b1, 1'b1);
        expect_at(2,            1'b0, 1'b1, "R10 lower still on");
        expect_at(3,            1'b0, 1'b0, "R10 lower released");
        expect_at(3 + DEAD - 1, 1'b0, 1'b0, "R10 gap end");
        expect_at(3 + DEAD,     1'b1, 1'b0, "R10 upper after gap");
        drain();

        // R4 long overlap then R7 exit
        drive(1'b1, 1'b0, 1'b1);
        expect_at(3,             1'b0, 1'b0, "R4 overlap off");
        expect_at(3 + DEAD + 10, 1'b0, 1'b0, "R4 overlap held");
        drain();
        drive(1'b1, 1'b1, 1'b1);
        expect_at(3 + DEAD - 1, 1'b0, 1'b0, "R7 exit still off");
        expect_at(3 + DEAD,     1'b1, 1'b0, "R7 exit upper on");
        drain();

        // R7 short overlap then lower
        drive(1'b1, 1'b0, 1'b1);
        expect_at(3, 1'b0, 1'b0, "R4 short overlap off");
        idle_for(2);
        drive(1'b0, 1'b0, 1'b1);
        expect_at(3 + DEAD - 1, 1'b0, 1'b0, "R7 short exit off");
        expect_at(3 + DEAD,     1'b0, 1'b1, "R7 short exit lower");
        drain();

        // R5 disarm
        drive(1'b0, 1'b0, 1'b0);
        expect_at(3, 1'b0, 1'b0, "R5 disarm off");
        drain(); idle_for(DEAD + 5);
        drive(1'b1, 1'b1, 1'b0);
        expect_at(3,            1'b0, 1'b0, "R5 request ignored");
        expect_at(3 + DEAD + 4, 1'b0, 1'b0, "R5 still ignored");
        drain();
        drive(1'b1, 1'b1, 1'b1);
        expect_at(3 + DEAD - 1, 1'b0, 1'b0, "R7 rearm off");
        expect_at(3 + DEAD,     1'b1, 1'b0, "R7 rearm upper");
        drain();

        // R8 reversal while counting
        drive(1'b0, 1'b0, 1'b1);
        expect_at(3, 1'b0, 1'b0, "R8 upper released");
        idle_for(2);
        drive(1'b1, 1'b1, 1'b1);
        expect_at(DEAD,         1'b0, 1'b0, "R8 old grant suppressed");
        expect_at(3 + DEAD - 1, 1'b0, 1'b0, "R8 restarted gap");
        expect_at(3 + DEAD,     1'b1, 1'b0, "R8 upper after restart");
        drain();

        // R8 short idle gap then lower
        drive(1'b0, 1'b1, 1'b1);
        expect_at(3, 1'b0, 1'b0, "R8 idle off");
        idle_for(1);
        drive(1'b0, 1'b0, 1'b1);
        expect_at(3 + DEAD - 1, 1'b0, 1'b0, "R8 short idle gap");
        expect_at(3 + DEAD,     1'b0, 1'b1, "R8 lower after gap");
        drain();

        drive(1'b0, 1'b0, 1'b0);
        expect_at(3, 1'b0, 1'b0, "R5 final disarm");
        drain();

        report();
        $finish;
    end
endmodule